// File: doc/BRIEF.md
# System Reset Sequencer

This block collects every reset request of a small microcontroller and turns them into one ordered reset sequence for the chip. There are four sources. The first is an external active-low pin, which must stay low for a minimum qualified width. The second is a software request strobe. The third is a watchdog underflow pulse, which has its own enable. The fourth is an oscillator-stop flag, which has a detection enable and an action-mode bit. The block arbitrates among the sources, records which ones have fired, and drives two reset levels. A full reset clears every register. A partial reset clears everything except a retained subset.

After the reset is released, the block either pulses a vector-fetch start strobe or holds the CPU halted, depending on the source. It also drives a clock-select override so that the CPU restarts on the internal oscillator. A watchdog underflow that is not allowed to reset, or an oscillator stop set to interrupt mode, leaves the block as a plain event output. A power-on input asynchronously forces the block into the same state a pin reset produces. The block leaves that state synchronously once power-on is released.

Top module: `sysrst_ctrl`

## Requirements
- R1: A pin reset is accepted only when the synchronized pin has stayed low for at least OSC_START_CYC + PIN_DLY_CYC + 1 consecutive cycles. Any shorter low pulse leaves every output unchanged.
- R2: An accepted pin reset asserts both `full_rst` and `part_rst` and holds them while the pin stays low. The vector strobe follows exactly 19 cycles after the pin returns high: 2 synchronizer cycles, 1 exit cycle and 16 stretch cycles.
- R3: A one-cycle `sw_rst_req` starts a partial reset. `part_rst` rises, `full_rst` stays low, and cause bit 1 is set.
- R4: A `wdt_uflow` pulse starts a partial reset only when `wdt_rst_en` is 1, and then sets cause bit 2. When `wdt_rst_en` is 0, the pulse appears on `wdt_event` in the same cycle and causes no reset.
- R5: `osc_stop` starts a partial reset only when `osc_det_en` is 1 and `osc_irq_mode` is 0, and then sets cause bit 3. That reset ends with `cpu_halt` high and no vector strobe. The halt is left only through a pin reset. With `osc_det_en` 1 and `osc_irq_mode` 1, `osc_irq` follows `osc_stop` in the same cycle and no reset occurs.
- R6: For software and watchdog resets, `part_rst` is high for exactly 16 cycles, starting in the cycle after the request. `vec_fetch` is then high for exactly one cycle, the first cycle with `part_rst` low.
- R7: `clk_int_sel` is high from reset entry through the vector-fetch cycle for pin, software and watchdog resets, and is low in the cycle after. It stays low for an oscillator-stop reset.
- R8: When several sources request in the same cycle, the priority is pin, then oscillator stop, then watchdog, then software. Only the winner's cause bit is set.
- R9: `rst_cause` bits are sticky: bit 0 is pin, bit 1 is software, bit 2 is watchdog, bit 3 is oscillator stop. Only a pin reset clears it, and it then reads 4'b0001.
- R10: While a reset sequence is running, or while the CPU is halted, requests other than the pin are ignored. Neither the cause register nor the timing changes.
- R11: While `por_n` is low, `full_rst`, `part_rst` and `clk_int_sel` are high and `rst_cause` is 4'b0001. After `por_n` is released, `vec_fetch` pulses in the 16th cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| pin_rst_n | input | 1 | External reset pin, active low, asynchronous to clk |
| sw_rst_req | input | 1 | Software reset request strobe |
| wdt_uflow | input | 1 | Watchdog underflow pulse |
| wdt_rst_en | input | 1 | 1: watchdog underflow resets |
| osc_stop | input | 1 | Main oscillator stop detected |
| osc_det_en | input | 1 | Oscillator-stop detection enable |
| osc_irq_mode | input | 1 | 1: stop raises an event, 0: stop resets |
| full_rst | output | 1 | Reset of all registers, including the retained set |
| part_rst | output | 1 | Reset of all registers except the retained set |
| clk_int_sel | output | 1 | Forces the CPU clock to the internal oscillator |
| cpu_halt | output | 1 | Holds the CPU stopped after an oscillator-stop reset |
| vec_fetch | output | 1 | One-cycle start strobe for the reset-vector fetch |
| rst_cause | output | 4 | Sticky reset-source record |
| wdt_event | output | 1 | Watchdog underflow passed on as a non-reset event |
| osc_irq | output | 1 | Oscillator stop passed on as a non-reset event |

## Verification
The assertions assume two things about the inputs. The watchdog, software and oscillator inputs are synchronous to `clk`. `por_n` is released away from a clock edge. The stimulus drives every input only just after a falling edge, so each request is one clean cycle wide. It also returns to the idle state through a pin reset before each new case, so no request arrives while the sequencer is in an unknown phase. The pin is driven the same way, but it is the only input that passes through the synchronizer, which makes its timing relative to `clk` irrelevant to the checks.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    localparam int SRC_N   = 4;
    localparam int SRC_PIN = 0;
    localparam int SRC_SW  = 1;
    localparam int SRC_WDT = 2;
    localparam int SRC_OSC = 3;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_HOLD,
        ST_STRETCH,
        ST_FETCH,
        ST_HALT
    } seq_state_e;

    // Source index at a given priority rank, 0 = highest.
    function automatic int src_at_rank(input int rank);
        case (rank)
            0:       return SRC_PIN;
            1:       return SRC_OSC;
            2:       return SRC_WDT;
            default: return SRC_SW;
        endcase
    endfunction

endpackage

// File: rtl/sysrst_pin_qual.sv
module sysrst_pin_qual #(
    parameter int OSC_START_CYC = 8,
    parameter int PIN_DLY_CYC   = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_rst_n,
    output logic pin_req
);
    localparam int THR = OSC_START_CYC + PIN_DLY_CYC;
    localparam int CW  = $clog2(THR + 1) + 1;
    localparam logic [CW-1:0] THR_C = CW'(THR);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] lowcnt;
    } qual_t;

    qual_t q_q, q_d;
    logic  pin_lo;

    always_comb begin
        q_d      = q_q;
        pin_lo   = !q_q.sync[1];
        q_d.sync = {q_q.sync[0], pin_rst_n};
        if (!pin_lo)
            q_d.lowcnt = '0;
        else if (q_q.lowcnt != THR_C)
            q_d.lowcnt = q_q.lowcnt + 1'b1;
        pin_req = pin_lo && (q_q.lowcnt >= THR_C);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q_q.sync   <= 2'b11;
            q_q.lowcnt <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    // R1: a request is only possible after the pin was already low
    p_req_after_low_r1: assert property (@(posedge clk) disable iff (!por_n)
        pin_req |-> $past(!q_q.sync[1]));

endmodule

// File: rtl/sysrst_arb.sv
module sysrst_arb
    import sysrst_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             pin_req,
    input  logic             sw_rst_req,
    input  logic             wdt_uflow,
    input  logic             wdt_rst_en,
    input  logic             osc_stop,
    input  logic             osc_det_en,
    input  logic             osc_irq_mode,
    output logic [SRC_N-1:0] grant,
    output logic             wdt_event,
    output logic             osc_irq
);
    logic [SRC_N-1:0] req;
    logic             taken;

    always_comb begin
        req          = '0;
        req[SRC_PIN] = pin_req;
        req[SRC_SW]  = sw_rst_req;
        req[SRC_WDT] = wdt_uflow && wdt_rst_en;
        req[SRC_OSC] = osc_stop && osc_det_en && !osc_irq_mode;
        wdt_event    = wdt_uflow && !wdt_rst_en;
        osc_irq      = osc_stop && osc_det_en && osc_irq_mode;
    end

    always_comb begin
        grant = '0;
        taken = 1'b0;
        for (int r = 0; r < SRC_N; r++) begin
            grant[src_at_rank(r)] = req[src_at_rank(r)] && !taken;
            taken                 = taken || req[src_at_rank(r)];
        end
    end

    p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(grant));
    p_pin_first_r8: assert property (@(posedge clk) disable iff (!por_n)
        pin_req |-> grant == 4'b0001);
    p_wdt_masked_r4: assert property (@(posedge clk) disable iff (!por_n)
        !wdt_rst_en |-> !grant[SRC_WDT]);
    p_osc_mode_r5: assert property (@(posedge clk) disable iff (!por_n)
        osc_irq |-> !grant[SRC_OSC]);

endmodule

// File: rtl/sysrst_seq.sv
module sysrst_seq
    import sysrst_pkg::*;
#(
    parameter int STRETCH_CYC = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [SRC_N-1:0] grant,
    output logic             full_rst,
    output logic             part_rst,
    output logic             clk_int_sel,
    output logic             cpu_halt,
    output logic             vec_fetch,
    output logic [SRC_N-1:0] rst_cause
);
    localparam int CW = (STRETCH_CYC > 2) ? $clog2(STRETCH_CYC) : 1;
    localparam logic [CW-1:0] LAST_C = CW'(STRETCH_CYC - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CW-1:0]    cnt;
        logic             full;
        logic             part;
        logic             clk_int;
        logic             halt;
        logic             vec;
        logic             stop_after;
        logic [SRC_N-1:0] cause;
    } seq_t;

    seq_t q_q, q_d;

    always_comb begin
        q_d     = q_q;
        q_d.vec = 1'b0;
        case (q_q.st)
            ST_RUN: begin
                if (|grant) begin
                    q_d.st         = ST_STRETCH;
                    q_d.cnt        = '0;
                    q_d.part       = 1'b1;
                    q_d.cause      = q_q.cause | grant;
                    q_d.stop_after = grant[SRC_OSC];
                    q_d.clk_int    = !grant[SRC_OSC];
                end
            end
            ST_HOLD: begin
                if (!grant[SRC_PIN]) begin
                    q_d.st  = ST_STRETCH;
                    q_d.cnt = '0;
                end
            end
            ST_STRETCH: begin
                if (q_q.cnt == LAST_C) begin
                    q_d.full = 1'b0;
                    q_d.part = 1'b0;
                    if (q_q.stop_after) begin
                        q_d.st   = ST_HALT;
                        q_d.halt = 1'b1;
                    end else begin
                        q_d.st  = ST_FETCH;
                        q_d.vec = 1'b1;
                    end
                end else begin
                    q_d.cnt = q_q.cnt + 1'b1;
                end
            end
            ST_FETCH: begin
                q_d.st      = ST_RUN;
                q_d.clk_int = 1'b0;
            end
            ST_HALT: begin
                q_d.halt = 1'b1;
            end
            default: q_d.st = ST_RUN;
        endcase
        // The pin pre-empts every state.
        if (grant[SRC_PIN]) begin
            q_d.st         = ST_HOLD;
            q_d.cnt        = '0;
            q_d.full       = 1'b1;
            q_d.part       = 1'b1;
            q_d.clk_int    = 1'b1;
            q_d.halt       = 1'b0;
            q_d.vec        = 1'b0;
            q_d.stop_after = 1'b0;
            q_d.cause      = 4'b0001;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q_q.st         <= ST_STRETCH;
            q_q.cnt        <= '0;
            q_q.full       <= 1'b1;
            q_q.part       <= 1'b1;
            q_q.clk_int    <= 1'b1;
            q_q.halt       <= 1'b0;
            q_q.vec        <= 1'b0;
            q_q.stop_after <= 1'b0;
            q_q.cause      <= 4'b0001;
        end else begin
            q_q <= q_d;
        end
    end

    assign full_rst    = q_q.full;
    assign part_rst    = q_q.part;
    assign clk_int_sel = q_q.clk_int;
    assign cpu_halt    = q_q.halt;
    assign vec_fetch   = q_q.vec;
    assign rst_cause   = q_q.cause;

    p_full_has_part_r2: assert property (@(posedge clk) disable iff (!por_n)
        full_rst |-> part_rst);
    p_vec_single_r6: assert property (@(posedge clk) disable iff (!por_n)
        vec_fetch |=> !vec_fetch);
    p_vec_after_rst_r6: assert property (@(posedge clk) disable iff (!por_n)
        vec_fetch |-> ($past(part_rst) && !part_rst));
    p_halt_no_vec_r5: assert property (@(posedge clk) disable iff (!por_n)
        cpu_halt |-> !vec_fetch);
    p_halt_stays_r5: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_halt && !grant[SRC_PIN]) |=> cpu_halt);
    p_halt_clk_r7: assert property (@(posedge clk) disable iff (!por_n)
        cpu_halt |-> !clk_int_sel);
    p_cause_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
        !grant[SRC_PIN] |=> ((rst_cause & $past(rst_cause)) == $past(rst_cause)));

endmodule

// File: rtl/sysrst_ctrl.sv
module sysrst_ctrl
    import sysrst_pkg::*;
#(
    parameter int OSC_START_CYC = 8,
    parameter int PIN_DLY_CYC   = 4,
    parameter int STRETCH_CYC   = 16
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       pin_rst_n,
    input  logic       sw_rst_req,
    input  logic       wdt_uflow,
    input  logic       wdt_rst_en,
    input  logic       osc_stop,
    input  logic       osc_det_en,
    input  logic       osc_irq_mode,
    output logic       full_rst,
    output logic       part_rst,
    output logic       clk_int_sel,
    output logic       cpu_halt,
    output logic       vec_fetch,
    output logic [3:0] rst_cause,
    output logic       wdt_event,
    output logic       osc_irq
);
    logic             pin_req;
    logic [SRC_N-1:0] grant;

    sysrst_pin_qual #(
        .OSC_START_CYC(OSC_START_CYC),
        .PIN_DLY_CYC  (PIN_DLY_CYC)
    ) u_qual (
        .clk      (clk),
        .por_n    (por_n),
        .pin_rst_n(pin_rst_n),
        .pin_req  (pin_req)
    );

    sysrst_arb u_arb (
        .clk         (clk),
        .por_n       (por_n),
        .pin_req     (pin_req),
        .sw_rst_req  (sw_rst_req),
        .wdt_uflow   (wdt_uflow),
        .wdt_rst_en  (wdt_rst_en),
        .osc_stop    (osc_stop),
        .osc_det_en  (osc_det_en),
        .osc_irq_mode(osc_irq_mode),
        .grant       (grant),
        .wdt_event   (wdt_event),
        .osc_irq     (osc_irq)
    );

    sysrst_seq #(
        .STRETCH_CYC(STRETCH_CYC)
    ) u_seq (
        .clk        (clk),
        .por_n      (por_n),
        .grant      (grant),
        .full_rst   (full_rst),
        .part_rst   (part_rst),
        .clk_int_sel(clk_int_sel),
        .cpu_halt   (cpu_halt),
        .vec_fetch  (vec_fetch),
        .rst_cause  (rst_cause)
    );

    // R10: a running sequence is never re-entered by a non-pin source
    p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!por_n)
        (part_rst && !full_rst && !pin_req) |=> !full_rst);

endmodule

// File: tb/sysrst_ctrl_test.sv
module sysrst_ctrl_test;
    localparam int OSC = 3;
    localparam int PIN = 2;
    localparam int T   = OSC + PIN + 1;

    logic clk = 1'b0;
    logic por_n = 1'b0, pin_rst_n = 1'b1, sw_rst_req = 1'b0, wdt_uflow = 1'b0;
    logic wdt_rst_en = 1'b0, osc_stop = 1'b0, osc_det_en = 1'b0, osc_irq_mode = 1'b0;
    logic full_rst, part_rst, clk_int_sel, cpu_halt, vec_fetch, wdt_event, osc_irq;
    logic [3:0] rst_cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sysrst_ctrl #(.OSC_START_CYC(OSC), .PIN_DLY_CYC(PIN), .STRETCH_CYC(16)) uut (
        .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n), .sw_rst_req(sw_rst_req),
        .wdt_uflow(wdt_uflow), .wdt_rst_en(wdt_rst_en), .osc_stop(osc_stop),
        .osc_det_en(osc_det_en), .osc_irq_mode(osc_irq_mode), .full_rst(full_rst),
        .part_rst(part_rst), .clk_int_sel(clk_int_sel), .cpu_halt(cpu_halt),
        .vec_fetch(vec_fetch), .rst_cause(rst_cause), .wdt_event(wdt_event),
        .osc_irq(osc_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        sw_rst_req = 0; wdt_uflow = 0; wdt_rst_en = 0;
        osc_stop = 0; osc_det_en = 0; osc_irq_mode = 0;
    endtask

    task automatic pin_reset();
        int n;
        pin_rst_n = 0;
        repeat (T + 4) tick();
        chk(full_rst == 1 && part_rst == 1, "R2", full_rst, 1);
        pin_rst_n = 1;
        n = 0;
        while (!vec_fetch && n < 40) begin
            tick();
            n++;
        end
        chk(n == 19, "R2", n, 19);
        chk(rst_cause == 4'b0001, "R9", rst_cause, 1);
        tick();
    endtask

    // One-cycle software reset run to completion from RUN.
    task automatic sw_reset_run();
        sw_rst_req = 1; tick(); sw_rst_req = 0;
        repeat (17) tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        bit seen;
        logic [3:0] expc;
        bit any, is_osc;

        // R11: power-on state and release
        repeat (3) tick();
        chk(full_rst && part_rst && clk_int_sel && !vec_fetch && !cpu_halt, "R11", full_rst, 1);
        chk(rst_cause == 4'b0001, "R11", rst_cause, 1);
        por_n = 1;
        n = 0;
        while (!vec_fetch && n < 40) begin
            tick();
            n++;
        end
        chk(n == 16, "R11", n, 16);
        tick();
        chk(!part_rst && !clk_int_sel && !vec_fetch, "R7", clk_int_sel, 0);

        // R1: pin low-width sweep around the threshold
        for (int len = 1; len <= T + 3; len++) begin
            pin_rst_n = 0;
            repeat (len) tick();
            pin_rst_n = 1;
            seen = 0;
            repeat (40) begin
                tick();
                if (full_rst) seen = 1;
            end
            chk(seen == (len >= T), "R1", seen, len >= T);
        end

        // Exhaustive sweep of the six request/control inputs (R3 R4 R5 R6 R7 R8)
        for (int m = 0; m < 64; m++) begin
            pin_reset();
            sw_rst_req = m[0]; wdt_uflow = m[1]; wdt_rst_en = m[2];
            osc_stop = m[3]; osc_det_en = m[4]; osc_irq_mode = m[5];
            is_osc = m[3] && m[4] && !m[5];
            any = is_osc || (m[1] && m[2]) || m[0];
            expc = 4'b0001;
            if (is_osc) expc[3] = 1;
            else if (m[1] && m[2]) expc[2] = 1;
            else if (m[0]) expc[1] = 1;
            #1;
            chk(wdt_event == (m[1] && !m[2]), "R4", wdt_event, m[1] && !m[2]);
            chk(osc_irq == (m[3] && m[4] && m[5]), "R5", osc_irq, m[3] && m[4] && m[5]);
            tick();
            idle_inputs();
            chk(rst_cause == expc, "R8", rst_cause, expc);
            chk(full_rst == 0, "R3", full_rst, 0);
            chk(clk_int_sel == (any && !is_osc), "R7", clk_int_sel, any && !is_osc);
            for (int k = 1; k <= 16; k++) begin
                if (k > 1) tick();
                chk(part_rst == any && !vec_fetch, "R6", part_rst, any);
            end
            tick();
            chk(!part_rst, "R6", part_rst, 0);
            chk(vec_fetch == (any && !is_osc), "R6", vec_fetch, any && !is_osc);
            chk(cpu_halt == is_osc, "R5", cpu_halt, is_osc);
            chk(clk_int_sel == (any && !is_osc), "R7", clk_int_sel, any && !is_osc);
            tick();
            chk(!vec_fetch && !clk_int_sel, "R7", clk_int_sel, 0);
            chk(cpu_halt == is_osc, "R5", cpu_halt, is_osc);
        end

        // R10: watchdog request during a software stretch is ignored
        pin_reset();
        sw_rst_req = 1; tick(); sw_rst_req = 0;
        repeat (3) tick();
        wdt_uflow = 1; wdt_rst_en = 1; tick(); idle_inputs();
        repeat (11) tick();
        chk(part_rst == 1 && !vec_fetch, "R10", part_rst, 1);
        tick();
        chk(vec_fetch == 1, "R10", vec_fetch, 1);
        chk(rst_cause == 4'b0011, "R10", rst_cause, 3);

        // R10 and R5: software request in halt is ignored; halt holds
        pin_reset();
        osc_stop = 1; osc_det_en = 1; tick(); idle_inputs();
        repeat (17) tick();
        sw_rst_req = 1; tick(); sw_rst_req = 0;
        seen = 0;
        repeat (20) begin
            tick();
            if (vec_fetch || part_rst) seen = 1;
        end
        chk(!seen && cpu_halt, "R10", seen, 0);
        chk(rst_cause == 4'b1001, "R5", rst_cause, 9);

        // R9: cause accumulates across partial resets; pin clears it
        pin_reset();
        chk(!cpu_halt, "R5", cpu_halt, 0);
        sw_reset_run();
        wdt_uflow = 1; wdt_rst_en = 1; tick(); idle_inputs();
        repeat (17) tick();
        chk(rst_cause == 4'b0111, "R9", rst_cause, 7);
        pin_reset();

        finish_run();
    end
endmodule